// File: doc/BRIEF.md
# Rotating-Key XOR Matrix Pipeline

This block is a radiation-upset test structure built as a long chain of identical rows. Each row holds a data register and a key register, both one word wide. A byte-wide stream first loads a key word and then a data word, one byte lane at a time. A controller then advances the chain for exactly as many cycles as it has rows. At each row the data word is XORed with that row's key, and the key moves to the next row rotated left by one bit, so every row applies a different key. The word that leaves the last row is then sent out one byte per cycle under a valid strobe.

The result is a closed-form function of the loaded words. If the key is K and the data is D, the output is D XORed with the XOR of K rotated left by 0, 1, ..., NUM_ROWS-1 positions. An upset in any data or key flip-flop during the run shows up as a difference from that value. While the chain advances or the result is being read out, the input stream is ignored.

Top module: `xor_key_matrix`

## Requirements
- R1: While rst_n is low, and in the first cycle after it is released, out_valid is 0 and out_byte is 0.
- R2: The first eight bytes accepted after idle form the key. The first accepted byte lands in key bits 7:0, the next in bits 15:8, and the eighth in bits 63:56.
- R3: The next eight accepted bytes form the data word, in the same lane order (first byte in bits 7:0, eighth in bits 63:56).
- R4: A byte is accepted only in a cycle where in_valid is 1. Cycles with in_valid at 0 during loading consume nothing and change no lane.
- R5: On the clock edge that accepts the eighth data byte, the chain starts advancing. out_valid rises NUM_ROWS edges later, stays high for exactly eight consecutive cycles, and is never high while the chain advances.
- R6: The output word equals D XOR (XOR over r = 0..NUM_ROWS-1 of K rotated left by r bits).
- R7: Output lanes leave in lane order: bits 7:0 in the first valid cycle, and bits 63:56 in the eighth.
- R8: in_valid and in_byte are ignored while the chain advances and during readout. A transaction that starts right after readout gives a correct result.
- R9: out_byte is 0 in every cycle where out_valid is 0.
- R10: On each advancing edge, every row after the first takes its predecessor's data XOR key as its new data, and its predecessor's key rotated left by one as its new key. Without an advancing edge, all rows hold their contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Qualifies in_byte during loading |
| in_byte | input | LANE_W | Key or data byte being loaded |
| out_valid | output | 1 | High for each of the eight result bytes |
| out_byte | output | LANE_W | Result byte, zero when out_valid is low |

## Verification
The checker verifies on every cycle that the output is zero while no readout is in progress and that readout bursts are exactly eight cycles long. It also checks that the strobe never overlaps an advancing cycle, and that each row's data and key follow its predecessor by one XOR and one rotation, or hold when the chain is idle. The bench's scenarios are needed to show what depends on whole transactions. These are the byte-lane assembly order, skipped idle cycles, the exact latency from the last data byte, the closed-form result for single-bit, zero and all-ones keys, and the fact that input traffic during a run leaves the next transaction unaffected.

// File: rtl/xkm_pkg.sv
package xkm_pkg;
   typedef enum logic [2:0] {
      XK_IDLE,
      XK_LOAD_KEY,
      XK_LOAD_DATA,
      XK_RUN,
      XK_UNLOAD
   } xk_state_t;
endpackage

// File: rtl/xkm_ctrl.sv
module xkm_ctrl #(
   parameter int LANES    = 8,
   parameter int NUM_ROWS = 26
) (
   input  logic                                      clk,
   input  logic                                      rst_n,
   input  logic                                      in_valid,
   output logic                                      key_we,
   output logic                                      data_we,
   output logic                                      adv,
   output logic                                      out_valid,
   output logic [((LANES > 1) ? $clog2(LANES) : 1)-1:0] lane_idx
);
   import xkm_pkg::*;

   localparam int LIDX_W = (LANES > 1) ? $clog2(LANES) : 1;
   localparam int MAXC   = (LANES > NUM_ROWS) ? LANES : NUM_ROWS;
   localparam int CNT_W  = $clog2(MAXC + 1);

   xk_state_t        state;
   logic [CNT_W-1:0] cnt;
   logic             lane_last;
   logic             run_last;

   assign lane_last = (cnt == CNT_W'(LANES - 1));
   assign run_last  = (cnt == CNT_W'(NUM_ROWS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= XK_IDLE;
         cnt   <= '0;
      end else begin
         case (state)
            XK_IDLE, XK_LOAD_KEY: begin
               if (in_valid) begin
                  if (lane_last) begin
                     state <= XK_LOAD_DATA;
                     cnt   <= '0;
                  end else begin
                     state <= XK_LOAD_KEY;
                     cnt   <= cnt + CNT_W'(1);
                  end
               end
            end
            XK_LOAD_DATA: begin
               if (in_valid) begin
                  if (lane_last) begin
                     state <= XK_RUN;
                     cnt   <= '0;
                  end else begin
                     cnt <= cnt + CNT_W'(1);
                  end
               end
            end
            XK_RUN: begin
               if (run_last) begin
                  state <= XK_UNLOAD;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + CNT_W'(1);
               end
            end
            XK_UNLOAD: begin
               if (lane_last) begin
                  state <= XK_IDLE;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + CNT_W'(1);
               end
            end
            default: begin
               state <= XK_IDLE;
               cnt   <= '0;
            end
         endcase
      end
   end

   assign key_we    = in_valid && ((state == XK_IDLE) || (state == XK_LOAD_KEY));
   assign data_we   = in_valid && (state == XK_LOAD_DATA);
   assign adv       = (state == XK_RUN);
   assign out_valid = (state == XK_UNLOAD);
   assign lane_idx  = cnt[LIDX_W-1:0];
endmodule

// File: rtl/xkm_loader.sv
module xkm_loader #(
   parameter int WORD_W = 64,
   parameter int LANE_W = 8
) (
   input  logic                                                clk,
   input  logic                                                rst_n,
   input  logic                                                key_we,
   input  logic                                                data_we,
   input  logic [(((WORD_W/LANE_W) > 1) ? $clog2(WORD_W/LANE_W) : 1)-1:0] lane_idx,
   input  logic [LANE_W-1:0]                                   in_byte,
   output logic [WORD_W-1:0]                                   key_word,
   output logic [WORD_W-1:0]                                   data_word
);
   localparam int LANES  = WORD_W / LANE_W;
   localparam int LIDX_W = (LANES > 1) ? $clog2(LANES) : 1;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] key_q;
      logic [LANE_W-1:0] data_q;
      logic              hit;

      assign hit = (lane_idx == LIDX_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            key_q  <= '0;
            data_q <= '0;
         end else begin
            if (key_we && hit)  key_q  <= in_byte;
            if (data_we && hit) data_q <= in_byte;
         end
      end

      assign key_word[g*LANE_W +: LANE_W]  = key_q;
      assign data_word[g*LANE_W +: LANE_W] = data_q;
   end
endmodule

// File: rtl/xkm_row.sv
module xkm_row #(
   parameter int WORD_W = 64,
   parameter int LANE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              adv,
   input  logic [WORD_W-1:0] data_in,
   input  logic [WORD_W-1:0] key_in,
   output logic [WORD_W-1:0] data_out,
   output logic [WORD_W-1:0] key_out
);
   localparam int LANES = WORD_W / LANE_W;

   for (genvar g = 0; g < LANES; g++) begin : g_cell
      logic [LANE_W-1:0] cell_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   cell_q <= '0;
         else if (adv) cell_q <= data_in[g*LANE_W +: LANE_W] ^ key_in[g*LANE_W +: LANE_W];
      end
      assign data_out[g*LANE_W +: LANE_W] = cell_q;
   end

   logic [WORD_W-1:0] key_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   key_q <= '0;
      else if (adv) key_q <= {key_in[WORD_W-2:0], key_in[WORD_W-1]};
   end
   assign key_out = key_q;
endmodule

// File: rtl/xor_key_matrix.sv
module xor_key_matrix #(
   parameter int NUM_ROWS = 26,
   parameter int WORD_W   = 64,
   parameter int LANE_W   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [LANE_W-1:0] in_byte,
   output logic              out_valid,
   output logic [LANE_W-1:0] out_byte
);
   localparam int LANES  = WORD_W / LANE_W;
   localparam int LIDX_W = (LANES > 1) ? $clog2(LANES) : 1;

   if ((WORD_W % LANE_W) != 0) begin : g_bad_lane
      $error("WORD_W must be a multiple of LANE_W");
   end
   if (LANES < 2) begin : g_bad_lanes
      $error("at least two byte lanes are required");
   end
   if (NUM_ROWS < 2) begin : g_bad_rows
      $error("NUM_ROWS must be at least 2");
   end

   logic              key_we, data_we, adv;
   logic [LIDX_W-1:0] lane_idx;
   logic [WORD_W-1:0] key_word, data_word;

   xkm_ctrl #(.LANES(LANES), .NUM_ROWS(NUM_ROWS)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .key_we    (key_we),
      .data_we   (data_we),
      .adv       (adv),
      .out_valid (out_valid),
      .lane_idx  (lane_idx)
   );

   xkm_loader #(.WORD_W(WORD_W), .LANE_W(LANE_W)) u_loader (
      .clk       (clk),
      .rst_n     (rst_n),
      .key_we    (key_we),
      .data_we   (data_we),
      .lane_idx  (lane_idx),
      .in_byte   (in_byte),
      .key_word  (key_word),
      .data_word (data_word)
   );

   logic [NUM_ROWS-1:0][WORD_W-1:0] row_din, row_kin, row_data, row_key;

   for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
      if (r == 0) begin : g_head
         assign row_din[r] = data_word;
         assign row_kin[r] = key_word;
      end else begin : g_link
         assign row_din[r] = row_data[r-1];
         assign row_kin[r] = row_key[r-1];
      end

      xkm_row #(.WORD_W(WORD_W), .LANE_W(LANE_W)) u_row (
         .clk      (clk),
         .rst_n    (rst_n),
         .adv      (adv),
         .data_in  (row_din[r]),
         .key_in   (row_kin[r]),
         .data_out (row_data[r]),
         .key_out  (row_key[r])
      );
   end

   logic [LANES-1:0][LANE_W-1:0] last_lanes;
   assign last_lanes = row_data[NUM_ROWS-1];
   assign out_byte   = out_valid ? last_lanes[lane_idx] : '0;
endmodule

// File: rtl/xor_key_matrix_chk.sv
module xor_key_matrix_chk #(
   parameter int NUM_ROWS = 26,
   parameter int WORD_W   = 64,
   parameter int LANE_W   = 8
) (
   input logic                            clk,
   input logic                            rst_n,
   input logic                            out_valid,
   input logic [LANE_W-1:0]               out_byte,
   input logic                            adv,
   input logic [NUM_ROWS-1:0][WORD_W-1:0] row_data,
   input logic [NUM_ROWS-1:0][WORD_W-1:0] row_key
);
   localparam int LANES = WORD_W / LANE_W;
   localparam int BW    = $clog2(LANES + 2);

   logic [BW-1:0] burst_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         burst_q <= '0;
      else if (out_valid) burst_q <= burst_q + BW'(1);
      else                burst_q <= '0;
   end

   p_quiet_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (out_byte == '0));

   p_burst_max_r5: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (burst_q < BW'(LANES)));

   p_burst_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(out_valid) |-> (burst_q == BW'(LANES)));

   p_no_overlap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      adv |-> !out_valid);

   for (genvar j = 1; j < NUM_ROWS; j++) begin : g_rowchk
      p_row_xor_r10: assert property (@(posedge clk) disable iff (!rst_n)
         $past(adv) |-> (row_data[j] == $past(row_data[j-1] ^ row_key[j-1])));

      p_key_rot_r10: assert property (@(posedge clk) disable iff (!rst_n)
         $past(adv) |-> (row_key[j] == {$past(row_key[j-1][WORD_W-2:0]), $past(row_key[j-1][WORD_W-1])}));

      p_row_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
         !$past(adv) |-> ($stable(row_data[j]) && $stable(row_key[j])));
   end
endmodule

bind xor_key_matrix xor_key_matrix_chk #(
   .NUM_ROWS (NUM_ROWS),
   .WORD_W   (WORD_W),
   .LANE_W   (LANE_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .out_valid (out_valid),
   .out_byte  (out_byte),
   .adv       (adv),
   .row_data  (row_data),
   .row_key   (row_key)
);

// File: tb/xor_key_matrix_tb.sv
module xor_key_matrix_tb;
   localparam int CLK_PERIOD = 10;
   localparam int NUM_ROWS   = 26;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic [7:0] in_byte = 8'h00;
   logic       out_valid;
   logic [7:0] out_byte;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   xor_key_matrix #(.NUM_ROWS(NUM_ROWS), .WORD_W(64), .LANE_W(8)) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_byte   (in_byte),
      .out_valid (out_valid),
      .out_byte  (out_byte)
   );

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [63:0] exp_res(input logic [63:0] k, input logic [63:0] d);
      logic [63:0] r = d;
      logic [63:0] kk = k;
      for (int i = 0; i < NUM_ROWS; i++) begin
         r  = r ^ kk;
         kk = {kk[62:0], kk[63]};
      end
      return r;
   endfunction

   // Behavioural reference: byte counter, wait counter, queue of pending output bytes
   logic [63:0] m_k, m_d, m_res;
   int          m_n = 0;
   int          m_wait = 0;
   logic [7:0]  m_q[$];

   always @(posedge clk) begin
      if (!rst_n) begin
         m_n = 0; m_wait = 0; m_q.delete();
      end else if (m_q.size() > 0) begin
         void'(m_q.pop_front());
      end else if (m_wait > 0) begin
         m_wait--;
         if (m_wait == 0) begin
            m_res = exp_res(m_k, m_d);
            for (int i = 0; i < 8; i++) m_q.push_back(m_res[8*i +: 8]);
         end
      end else if (in_valid) begin
         if (m_n < 8) m_k[8*m_n +: 8] = in_byte;
         else         m_d[8*(m_n-8) +: 8] = in_byte;
         m_n++;
         if (m_n == 16) begin
            m_n = 0;
            m_wait = NUM_ROWS;
         end
      end
   end

   // Per-cycle comparison against the reference, away from the active edge
   always @(negedge clk) begin
      if (!rst_n) begin
         chk(!out_valid && out_byte == 8'h00, "R1", {out_valid, out_byte}, 0);
      end else begin
         logic       ev;
         logic [7:0] eb;
         ev = (m_q.size() > 0);
         eb = ev ? m_q[0] : 8'h00;
         chk(out_valid == ev, "R5", 64'(out_valid), 64'(ev));
         chk(out_byte == eb, ev ? "R6" : "R9", 64'(out_byte), 64'(eb));
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 50000) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 50000);
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   task automatic txn(input logic [63:0] k, input logic [63:0] d, input int gap,
                      input bit noise, input string tag);
      logic [63:0] got;
      logic [63:0] want;
      int          lat;
      want = exp_res(k, d);
      for (int i = 0; i < 16; i++) begin
         @(negedge clk);
         in_valid = 1'b1;
         in_byte  = (i < 8) ? k[8*i +: 8] : d[8*(i-8) +: 8];
         if (gap > 0 && i < 15) begin
            for (int g = 0; g < gap; g++) begin
               @(negedge clk);
               in_valid = 1'b0;
               in_byte  = 8'hA5;
            end
         end
      end
      lat = 0;
      do begin
         @(negedge clk);
         lat++;
         in_valid = noise;
         in_byte  = 8'($urandom);
      end while (!out_valid && lat < 200);
      chk(lat == NUM_ROWS + 1, "R5", 64'(lat), 64'(NUM_ROWS + 1));
      got = '0;
      got[7:0] = out_byte;
      chk(out_byte == want[7:0], "R7", 64'(out_byte), 64'(want[7:0]));
      for (int i = 1; i < 8; i++) begin
         @(negedge clk);
         chk(out_valid == 1'b1, "R5", 64'(out_valid), 64'd1);
         got[8*i +: 8] = out_byte;
         in_valid = noise;
         in_byte  = 8'($urandom);
      end
      @(negedge clk);
      chk(out_valid == 1'b0, "R5", 64'(out_valid), 64'd0);
      in_valid = 1'b0;
      in_byte  = 8'h00;
      chk(got == want, tag, got, want);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!out_valid && out_byte == 8'h00, "R1", {out_valid, out_byte}, 0);

      // R2: zero data exposes the key's lane assembly
      txn(64'h0123_4567_89AB_CDEF, 64'h0, 0, 1'b0, "R2");
      // R3: zero key passes data straight through
      txn(64'h0, 64'hDEAD_BEEF_CAFE_F00D, 0, 1'b0, "R3");
      // R6: general pattern
      txn(64'h1357_9BDF_0246_8ACE, 64'hF0E1_D2C3_B4A5_9687, 0, 1'b0, "R6");
      // R6: all-ones key cancels over an even number of rows
      txn(64'hFFFF_FFFF_FFFF_FFFF, 64'h5A5A_A5A5_3C3C_C3C3, 0, 1'b0, "R6");
      chk(exp_res(64'hFFFF_FFFF_FFFF_FFFF, 64'h1) == 64'h1, "R6",
          exp_res(64'hFFFF_FFFF_FFFF_FFFF, 64'h1), 64'h1);
      // R10: single key bit walks across bits 63, 0..24
      txn(64'h8000_0000_0000_0000, 64'h0, 0, 1'b0, "R10");
      chk(exp_res(64'h8000_0000_0000_0000, 64'h0) == 64'h8000_0000_01FF_FFFF, "R10",
          exp_res(64'h8000_0000_0000_0000, 64'h0), 64'h8000_0000_01FF_FFFF);
      // R4: idle cycles between loaded bytes
      txn(64'hA1B2_C3D4_E5F6_0718, 64'h2939_4A5B_6C7D_8E9F, 2, 1'b0, "R4");
      // R8: traffic during run and readout, then a clean transaction back to back
      txn(64'h0F1E_2D3C_4B5A_6978, 64'h8796_A5B4_C3D2_E1F0, 0, 1'b1, "R8");
      txn(64'hC001_D00D_BAAD_F00D, 64'h1234_5678_9ABC_DEF0, 0, 1'b0, "R8");

      repeat (5) @(negedge clk);
      chk(out_valid == 1'b0 && out_byte == 8'h00, "R9", {out_valid, out_byte}, 0);

      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule